// File: doc/BRIEF.md
# Aliased General-Purpose Register File

This block holds eight 32-bit general-purpose registers. Each register can be reached through a full 32-bit view, a 16-bit view of its low half, or, for the first four registers only, two separate 8-bit views of that low half. All views of a register share the same storage. A narrow write changes only the bits its view covers and leaves every other bit as it was. A narrow read returns its field right-aligned, with zeros above it.

There are two combinational read ports and one write port that updates on the rising clock edge. Each port takes a register index and a view select. An 8-bit view of a register that has no byte views is rejected. The port raises an error flag, a read returns zero, and a write leaves the register file untouched. A read in the same cycle as a write to the same register returns the value from before the write.

Register indices: 0 accumulator, 1 counter, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index. View select encoding: 0 = full 32-bit, 1 = low 16-bit, 2 = byte at bits 7:0, 3 = byte at bits 15:8.

Top module: `gpr_alias_file`

## Requirements
- R1: After reset every register reads zero through the full view (view 0) on both read ports.
- R2: A write with view 0 replaces all 32 bits of the selected register, and a view 0 read returns all 32 bits.
- R3: A write with view 1 sets bits 15:0 from write data bits 15:0 and keeps bits 31:16. A view 1 read returns bits 15:0 zero-extended.
- R4: For indices 0 to 3, a write with view 2 sets bits 7:0 from write data bits 7:0 and keeps all other bits. A view 2 read returns bits 7:0 zero-extended.
- R5: For indices 0 to 3, a write with view 3 sets bits 15:8 from write data bits 7:0 and keeps all other bits. A view 3 read returns bits 15:8 in result bits 7:0, with zeros above.
- R6: A view 2 or view 3 access to indices 4 to 7 raises that port's error flag. A read returns zero and a write changes no register. The error flag is low for every other access, and the write error flag is low while the write enable is low.
- R7: A write takes effect at the clock edge. A read of the target register in the same cycle returns the old value, and the new value is visible in the following cycle.
- R8: The two read ports select register and view independently and may read different registers at the same time.
- R9: A write changes no register other than the one it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_idx | input | 3 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view select |
| rd0_data | output | 32 | Read port 0 data, zero-extended |
| rd0_err | output | 1 | Read port 0 illegal view flag |
| rd1_idx | input | 3 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view select |
| rd1_data | output | 32 | Read port 1 data, zero-extended |
| rd1_err | output | 1 | Read port 1 illegal view flag |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 3 | Write register index |
| wr_view | input | 2 | Write view select |
| wr_data | input | 32 | Write data, narrow views take the low bits |
| wr_err | output | 1 | Write illegal view flag; the write is dropped |

## Verification
A wrong merge during a narrow write leaves bad bits outside the written field. These are not visible through the narrow view that wrote them, so the bench reads every register back through the full view one cycle after each write. A wrongly decoded write target shows up as a changed neighbouring register in that same readback. A missing write suppression on an illegal byte access shows as a changed full-view value one cycle later. Read muxing errors are combinational and show in the same cycle that the index and view are applied.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        VIEW_FULL = 2'd0,
        VIEW_HALF = 2'd1,
        VIEW_LO8  = 2'd2,
        VIEW_HI8  = 2'd3
    } view_e;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned HALF_W = 2 * BYTE_W;

    function automatic logic view_is_byte(input view_e v);
        return (v == VIEW_LO8) || (v == VIEW_HI8);
    endfunction

    function automatic logic view_allowed(input int unsigned idx,
                                          input view_e v,
                                          input int unsigned byte_regs);
        return !(view_is_byte(v) && (idx >= byte_regs));
    endfunction

endpackage

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS       = 8,
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned BYTE_VIEW_REGS = 4,
    localparam int unsigned IDX_W         = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic [1:0]                      view_i,
    output logic [DATA_W-1:0]               data_o,
    output logic                            err_o
);

    logic [DATA_W-1:0] sel_word;
    view_e             view;
    logic              legal;

    always_comb begin
        view     = view_e'(view_i);
        sel_word = regs_i[idx_i];
        legal    = view_allowed(int'(idx_i), view, BYTE_VIEW_REGS);
        data_o   = '0;
        if (legal) begin
            unique case (view)
                VIEW_FULL: data_o = sel_word;
                VIEW_HALF: data_o = DATA_W'(sel_word[HALF_W-1:0]);
                VIEW_LO8:  data_o = DATA_W'(sel_word[BYTE_W-1:0]);
                VIEW_HI8:  data_o = DATA_W'(sel_word[HALF_W-1:BYTE_W]);
                default:   data_o = '0;
            endcase
        end
        err_o = !legal;
    end

endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] old_i,
    input  logic [1:0]        view_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] new_o
);

    always_comb begin
        new_o = old_i;
        unique case (view_e'(view_i))
            VIEW_FULL: new_o = data_i;
            VIEW_HALF: new_o[HALF_W-1:0] = data_i[HALF_W-1:0];
            VIEW_LO8:  new_o[BYTE_W-1:0] = data_i[BYTE_W-1:0];
            VIEW_HI8:  new_o[HALF_W-1:BYTE_W] = data_i[BYTE_W-1:0];
            default:   new_o = old_i;
        endcase
    end

endmodule

// File: rtl/gpr_write_decode.sv
module gpr_write_decode
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS       = 8,
    parameter int unsigned BYTE_VIEW_REGS = 4,
    localparam int unsigned IDX_W         = $clog2(NUM_REGS)
) (
    input  logic                en_i,
    input  logic [IDX_W-1:0]    idx_i,
    input  logic [1:0]          view_i,
    output logic [NUM_REGS-1:0] sel_o,
    output logic                err_o
);

    logic legal;

    assign legal = view_allowed(int'(idx_i), view_e'(view_i), BYTE_VIEW_REGS);
    assign err_o = en_i && !legal;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel_o[g] = en_i && legal && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS       = 8,
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned BYTE_VIEW_REGS = 4,
    localparam int unsigned IDX_W         = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_view,
    output logic [DATA_W-1:0] rd0_data,
    output logic              rd0_err,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_view,
    output logic [DATA_W-1:0] rd1_data,
    output logic              rd1_err,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_view,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err
);

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } state_t;

    state_t              state_d, state_q;
    logic [NUM_REGS-1:0] wr_sel;
    logic [DATA_W-1:0]   wr_old;
    logic [DATA_W-1:0]   wr_merged;

    gpr_write_decode #(
        .NUM_REGS       (NUM_REGS),
        .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
    ) u_wdec (
        .en_i   (wr_en),
        .idx_i  (wr_idx),
        .view_i (wr_view),
        .sel_o  (wr_sel),
        .err_o  (wr_err)
    );

    assign wr_old = state_q.regs[wr_idx];

    gpr_write_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .old_i  (wr_old),
        .view_i (wr_view),
        .data_i (wr_data),
        .new_o  (wr_merged)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_sel[i]) begin
                state_d.regs[i] = wr_merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    gpr_read_port #(
        .NUM_REGS       (NUM_REGS),
        .DATA_W         (DATA_W),
        .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
    ) u_rd0 (
        .regs_i (state_q.regs),
        .idx_i  (rd0_idx),
        .view_i (rd0_view),
        .data_o (rd0_data),
        .err_o  (rd0_err)
    );

    gpr_read_port #(
        .NUM_REGS       (NUM_REGS),
        .DATA_W         (DATA_W),
        .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
    ) u_rd1 (
        .regs_i (state_q.regs),
        .idx_i  (rd1_idx),
        .view_i (rd1_view),
        .data_o (rd1_data),
        .err_o  (rd1_err)
    );

endmodule

// File: rtl/gpr_alias_chk.sv
module gpr_alias_chk
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS       = 8,
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned BYTE_VIEW_REGS = 4,
    localparam int unsigned IDX_W         = $clog2(NUM_REGS)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [IDX_W-1:0]                rd0_idx,
    input logic [1:0]                      rd0_view,
    input logic [DATA_W-1:0]               rd0_data,
    input logic                            rd0_err,
    input logic                            wr_en,
    input logic [IDX_W-1:0]                wr_idx,
    input logic [1:0]                      wr_view,
    input logic                            wr_err,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);

    // R6
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_err |-> (rd0_data == '0));

    // R6
    wide_view_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_view[1] == 1'b0) |-> !rd0_err);

    // R6
    bad_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_err || !wr_en) |=> (regs == $past(regs)));

    // R3
    half_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd1)
        |=> (regs[$past(wr_idx)][DATA_W-1:HALF_W] ==
             $past(regs[wr_idx][DATA_W-1:HALF_W])));

    // R5
    high_byte_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_err && wr_view == 2'd3)
        |=> ((regs[$past(wr_idx)][BYTE_W-1:0] == $past(regs[wr_idx][BYTE_W-1:0])) &&
             (regs[$past(wr_idx)][DATA_W-1:HALF_W] ==
              $past(regs[wr_idx][DATA_W-1:HALF_W]))));

    // R6
    write_err_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_err);

endmodule

bind gpr_alias_file gpr_alias_chk #(
    .NUM_REGS       (NUM_REGS),
    .DATA_W         (DATA_W),
    .BYTE_VIEW_REGS (BYTE_VIEW_REGS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_idx  (rd0_idx),
    .rd0_view (rd0_view),
    .rd0_data (rd0_data),
    .rd0_err  (rd0_err),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_view  (wr_view),
    .wr_err   (wr_err),
    .regs     (state_q.regs)
);

// File: tb/gpr_alias_file_tb.sv
`timescale 1ns/1ps
module gpr_alias_file_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [1:0]  rd0_view = '0, rd1_view = '0, wr_view = '0;
    logic [31:0] rd0_data, rd1_data, wr_data = '0;
    logic        rd0_err, rd1_err, wr_en = 1'b0, wr_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model [8];

    always #2.5 clk = ~clk;

    gpr_alias_file u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(rd0_idx), .rd0_view(rd0_view), .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_idx(rd1_idx), .rd1_view(rd1_view), .rd1_data(rd1_data), .rd1_err(rd1_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data),
        .wr_err(wr_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] apply_write(input logic [31:0] old,
                                                input logic [1:0] v,
                                                input logic [31:0] d);
        case (v)
            2'd0:    return d;
            2'd1:    return {old[31:16], d[15:0]};
            2'd2:    return {old[31:8], d[7:0]};
            default: return {old[31:16], d[7:0], old[7:0]};
        endcase
    endfunction

    function automatic logic [31:0] view_of(input logic [31:0] w, input logic [1:0] v);
        case (v)
            2'd0:    return w;
            2'd1:    return {16'h0, w[15:0]};
            2'd2:    return {24'h0, w[7:0]};
            default: return {24'h0, w[15:8]};
        endcase
    endfunction

    task automatic do_write(input logic [2:0] idx, input logic [1:0] v, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_view = v; wr_data = d;
        @(posedge clk);
        if (!(v[1] && idx >= 3'd4)) model[idx] = apply_write(model[idx], v, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read0(input logic [2:0] idx, input logic [1:0] v,
                         input string req, input logic [31:0] exp);
        rd0_idx = idx; rd0_view = v;
        #1;
        chk(req, rd0_data, exp);
    endtask

    task automatic check_all_full(input string req);
        @(negedge clk);
        for (int i = 0; i < 8; i++) read0(3'(i), 2'd0, req, model[i]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rd1_idx = 3'(i); rd1_view = 2'd0;
            read0(3'(i), 2'd0, "R1 rd0", 32'h0);
            chk("R1 rd1", rd1_data, 32'h0);
        end
    endtask

    task automatic t_full();
        do_write(3'd0, 2'd0, 32'hDEADBEEF);
        do_write(3'd7, 2'd0, 32'h12345678);
        read0(3'd0, 2'd0, "R2 full acc", 32'hDEADBEEF);
        read0(3'd7, 2'd0, "R2 full di", 32'h12345678);
        do_write(3'd0, 2'd0, 32'h0BADF00D);
        read0(3'd0, 2'd0, "R2 full overwrite", 32'h0BADF00D);
    endtask

    task automatic t_half();
        do_write(3'd1, 2'd0, 32'hAAAA5555);
        do_write(3'd1, 2'd1, 32'hFFFF1234);
        read0(3'd1, 2'd0, "R3 half keeps upper", 32'hAAAA1234);
        read0(3'd1, 2'd1, "R3 half read", 32'h00001234);
        do_write(3'd5, 2'd0, 32'hCAFEBABE);
        do_write(3'd5, 2'd1, 32'h00009876);
        read0(3'd5, 2'd0, "R3 half on bp", 32'hCAFE9876);
        read0(3'd5, 2'd1, "R3 half read bp", 32'h00009876);
    endtask

    task automatic t_low_byte();
        do_write(3'd2, 2'd0, 32'h11223344);
        do_write(3'd2, 2'd2, 32'hFFFFFF99);
        read0(3'd2, 2'd0, "R4 low byte merge", 32'h11223399);
        read0(3'd2, 2'd2, "R4 low byte read", 32'h00000099);
    endtask

    task automatic t_high_byte();
        do_write(3'd3, 2'd0, 32'h55667788);
        do_write(3'd3, 2'd3, 32'hFFFFFFA5);
        read0(3'd3, 2'd0, "R5 high byte merge", 32'h5566A588);
        read0(3'd3, 2'd3, "R5 high byte read", 32'h000000A5);
        read0(3'd3, 2'd2, "R5 low byte intact", 32'h00000088);
    endtask

    task automatic t_illegal();
        do_write(3'd4, 2'd0, 32'h87654321);
        for (int i = 4; i < 8; i++) begin
            for (int v = 2; v < 4; v++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_idx = 3'(i); wr_view = 2'(v); wr_data = 32'hFFFFFFFF;
                rd0_idx = 3'(i); rd0_view = 2'(v);
                #1;
                chk("R6 wr_err", {31'h0, wr_err}, 32'h1);
                chk("R6 rd_err", {31'h0, rd0_err}, 32'h1);
                chk("R6 rd zero", rd0_data, 32'h0);
                @(negedge clk);
                wr_en = 1'b0;
            end
        end
        check_all_full("R6 write suppressed");
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd1; wr_view = 2'd3;
        rd0_idx = 3'd6; rd0_view = 2'd1;
        #1;
        chk("R6 legal byte no err", {31'h0, wr_err}, 32'h0);
        chk("R6 half no err", {31'h0, rd0_err}, 32'h0);
        wr_en = 1'b0;
        #0.5;
        wr_idx = 3'd5; wr_view = 2'd2;
        #0.5;
        chk("R6 no err when idle", {31'h0, wr_err}, 32'h0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] old;
        old = model[6];
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd6; wr_view = 2'd0; wr_data = 32'h600DCAFE;
        rd0_idx = 3'd6; rd0_view = 2'd0;
        #1;
        chk("R7 old value same cycle", rd0_data, old);
        @(posedge clk);
        model[6] = 32'h600DCAFE;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        chk("R7 new value next cycle", rd0_data, 32'h600DCAFE);
    endtask

    task automatic t_dual_read();
        @(negedge clk);
        rd1_idx = 3'd3; rd1_view = 2'd3;
        read0(3'd1, 2'd1, "R8 port0", view_of(model[1], 2'd1));
        chk("R8 port1", rd1_data, view_of(model[3], 2'd3));
        rd1_idx = 3'd7; rd1_view = 2'd2;
        #1;
        chk("R8 port1 err", {31'h0, rd1_err}, 32'h1);
        chk("R8 port0 unaffected", rd0_data, view_of(model[1], 2'd1));
    endtask

    task automatic t_isolation();
        do_write(3'd2, 2'd0, 32'hFEEDFACE);
        check_all_full("R9 after full");
        do_write(3'd0, 2'd3, 32'h0000007E);
        check_all_full("R9 after high byte");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_half();
        t_low_byte();
        t_high_byte();
        t_illegal();
        t_same_cycle();
        t_dual_read();
        t_isolation();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule